// File: doc/BRIEF.md
# Next Program Counter Selector

This block works out the address of the next instruction for an 8-bit controller that has a 16-bit program space. The fetch stage gives it one instruction at a time. Each instruction comes with the current program counter, the instruction length in bytes, the opcode, an offset byte, a page operand byte, a full 16-bit target, the accumulator, the data pointer and the result of the branch condition. One cycle later the block returns the next program counter and a flag that tells whether control left the sequential path.

The decoder sorts each opcode into one of six selection kinds. `K_SEQ` is every opcode that does not transfer control. `K_COND` is a relative branch that depends on the condition input. `K_SHORT` is the unconditional short relative jump. `K_PAGE` is the jump or call to an 11-bit address inside the current 2 KB page. `K_LONG` is the jump or call to a full 16-bit address. `K_INDIR` is the jump through accumulator plus data pointer. There is one transition: on each clock edge with `in_valid` high, the output register loads the target of the selected kind. With `in_valid` low, the register holds its value.

The sequential address is `cur_pc + instr_len`. All relative targets and the page base are taken from that sequential address, not from `cur_pc`. Every sum wraps modulo 65536.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` and `branch_taken` are 0 and `next_pc` is 16'h0000, until the first accepted instruction.
- R2: Any opcode that is not listed in R3 to R7 gives `next_pc = cur_pc + instr_len` and `branch_taken = 0`. `cond_taken` has no effect on these opcodes.
- R3: The conditional relative opcodes are 8'h10, 20, 30, 40, 50, 60, 70, D5, B4 to BF and D8 to DF. When `cond_taken` is 1, the result is the sequential address plus the sign-extended `rel_off` (-128 to +127) and `branch_taken = 1`. When `cond_taken` is 0, the result is the sequential address and `branch_taken = 0`.
- R4: Opcode 8'h80 always branches to the sequential address plus the sign-extended `rel_off`, whatever the value of `cond_taken`.
- R5: Any opcode whose low nibble is 4'h1 gives `{seq[15:11], opcode[7:5], page_lo}`, where `seq` is the sequential address. `branch_taken` is 1 and `cond_taken` has no effect.
- R6: Opcodes 8'h02 and 8'h12 give `next_pc = abs_addr` with `branch_taken = 1`.
- R7: Opcode 8'h73 gives `next_pc = dptr + acc` (a 16-bit sum) with `branch_taken = 1`.
- R8: All sequential, relative and indirect sums wrap modulo 65536 and raise no flag.
- R9: `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, `next_pc` and `branch_taken` hold their values.
- R10: `branch_taken` is 1 exactly when the selected target is not the sequential address because of the kind: it is 1 for K_SHORT, K_PAGE, K_LONG and K_INDIR, and for K_COND when `cond_taken` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction fields are valid this cycle |
| cur_pc | input | 16 | Address of the instruction's first byte |
| instr_len | input | 2 | Instruction length, 1 to 3 bytes |
| opcode | input | 8 | Instruction opcode |
| rel_off | input | 8 | Signed relative offset |
| page_lo | input | 8 | Low byte of the in-page target |
| abs_addr | input | 16 | Full 16-bit target |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| cond_taken | input | 1 | Branch condition result |
| out_valid | output | 1 | `next_pc` holds a new result |
| next_pc | output | 16 | Selected next program counter |
| branch_taken | output | 1 | Control left the sequential path |

## Verification
Every result shows up exactly one clock edge after the instruction fields are presented with `in_valid` high. No result takes more than one cycle. The bench drives the inputs at a falling edge and lets one rising edge pass. It then samples at the next falling edge, where the registered outputs have settled. The hold behaviour is checked the same way: `in_valid` is dropped, the fields are scrambled, and the bench checks on the following falling edge that nothing moved.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    localparam int unsigned OP_W  = 8;
    localparam int unsigned LEN_W = 2;

    typedef enum logic [2:0] {
        K_SEQ   = 3'd0,
        K_COND  = 3'd1,
        K_SHORT = 3'd2,
        K_PAGE  = 3'd3,
        K_LONG  = 3'd4,
        K_INDIR = 3'd5
    } pcu_kind_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
    import pcu_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output pcu_kind_e       kind
);
    logic is_cond;

    always_comb begin
        is_cond = 1'b0;
        // bit-test, carry, zero tests: rows 1..7 of column 0
        if (opcode[3:0] == 4'h0 && opcode[7:4] >= 4'h1 && opcode[7:4] <= 4'h7)
            is_cond = 1'b1;
        // compare-and-jump-if-not-equal: B4..BF
        if (opcode[7:4] == 4'hB && opcode[3:2] != 2'b00)
            is_cond = 1'b1;
        // decrement-and-jump: D5 and D8..DF
        if (opcode == 8'hD5 || opcode[7:3] == 5'b11011)
            is_cond = 1'b1;
    end

    always_comb begin
        kind = K_SEQ;
        if (opcode[3:0] == 4'h1)
            kind = K_PAGE;
        else if (opcode == 8'h02 || opcode == 8'h12)
            kind = K_LONG;
        else if (opcode == 8'h73)
            kind = K_INDIR;
        else if (opcode == 8'h80)
            kind = K_SHORT;
        else if (is_cond)
            kind = K_COND;
    end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 11
) (
    input  pcu_kind_e         kind,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic [OP_W-1:0]   opcode,
    input  logic [7:0]        rel_off,
    input  logic [7:0]        page_lo,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [7:0]        acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic              cond_taken,
    output logic [ADDR_W-1:0] target,
    output logic              taken
);
    localparam int unsigned EXT_W = ADDR_W - 8;
    localparam int unsigned HI_W  = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] rel_addr;
    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] ind_addr;

    assign seq_addr  = cur_pc + ADDR_W'(instr_len);
    assign rel_addr  = seq_addr + {{EXT_W{rel_off[7]}}, rel_off};
    assign page_addr = {seq_addr[ADDR_W-1 -: HI_W], opcode[7:5], page_lo};
    assign ind_addr  = dptr + ADDR_W'(acc);

    always_comb begin
        target = seq_addr;
        taken  = 1'b0;
        unique case (kind)
            K_SEQ: begin
                target = seq_addr;
                taken  = 1'b0;
            end
            K_COND: begin
                target = cond_taken ? rel_addr : seq_addr;
                taken  = cond_taken;
            end
            K_SHORT: begin
                target = rel_addr;
                taken  = 1'b1;
            end
            K_PAGE: begin
                target = page_addr;
                taken  = 1'b1;
            end
            K_LONG: begin
                target = abs_addr;
                taken  = 1'b1;
            end
            K_INDIR: begin
                target = ind_addr;
                taken  = 1'b1;
            end
            default: begin
                target = seq_addr;
                taken  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [1:0]        instr_len,
    input  logic [7:0]        opcode,
    input  logic [7:0]        rel_off,
    input  logic [7:0]        page_lo,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [7:0]        acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic              cond_taken,
    output logic              out_valid,
    output logic [ADDR_W-1:0] next_pc,
    output logic              branch_taken
);
    pcu_kind_e         kind;
    logic [ADDR_W-1:0] target;
    logic              taken;

    pcu_decode u_dec (
        .opcode (opcode),
        .kind   (kind)
    );

    pcu_target #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_tgt (
        .kind       (kind),
        .cur_pc     (cur_pc),
        .instr_len  (instr_len),
        .opcode     (opcode),
        .rel_off    (rel_off),
        .page_lo    (page_lo),
        .abs_addr   (abs_addr),
        .acc        (acc),
        .dptr       (dptr),
        .cond_taken (cond_taken),
        .target     (target),
        .taken      (taken)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            next_pc      <= '0;
            branch_taken <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                next_pc      <= target;
                branch_taken <= taken;
            end
        end
    end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [1:0]        instr_len,
    input logic [7:0]        opcode,
    input logic [ADDR_W-1:0] abs_addr,
    input logic [7:0]        acc,
    input logic [ADDR_W-1:0] dptr,
    input logic              out_valid,
    input logic [ADDR_W-1:0] next_pc,
    input logic              branch_taken
);
    logic [ADDR_W-1:0] seq_ref;
    logic [ADDR_W-1:0] ind_ref;
    assign seq_ref = cur_pc + ADDR_W'(instr_len);
    assign ind_ref = dptr + ADDR_W'(acc);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(next_pc) && $stable(branch_taken)));
    assert_nop_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h00) |=> (next_pc == $past(seq_ref) && !branch_taken));
    assert_long_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 8'h02 || opcode == 8'h12)) |=> (next_pc == $past(abs_addr) && branch_taken));
    assert_indirect_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h73) |=> (next_pc == $past(ind_ref) && branch_taken));
    assert_short_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 8'h80) |=> branch_taken);
endmodule

bind pc_next_unit pcu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .cur_pc       (cur_pc),
    .instr_len    (instr_len),
    .opcode       (opcode),
    .abs_addr     (abs_addr),
    .acc          (acc),
    .dptr         (dptr),
    .out_valid    (out_valid),
    .next_pc      (next_pc),
    .branch_taken (branch_taken)
);

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] pc;
        logic [1:0]  len;
        logic [7:0]  op;
        logic [7:0]  rel;
        logic [7:0]  pg;
        logic [15:0] abs;
        logic [7:0]  a;
        logic [15:0] dp;
        logic        cond;
        logic [15:0] exp_pc;
        logic        exp_tk;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 16'h1000, 2'd1, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h1001, 1'b0}, // R2 NOP
        '{4'd2, 16'h2000, 2'd2, 8'h74, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h2002, 1'b0}, // R2
        '{4'd2, 16'h3000, 2'd1, 8'h04, 8'h40, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h3001, 1'b0}, // R2 cond ignored
        '{4'd6, 16'h0100, 2'd3, 8'h02, 8'h00, 8'h00, 16'hBEEF, 8'h00, 16'h0000, 1'b0, 16'hBEEF, 1'b1}, // R6 R10
        '{4'd6, 16'h0200, 2'd3, 8'h12, 8'h00, 8'h00, 16'h1234, 8'h00, 16'h0000, 1'b0, 16'h1234, 1'b1}, // R6
        '{4'd4, 16'h0300, 2'd2, 8'h80, 8'h10, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0312, 1'b1}, // R4
        '{4'd4, 16'h0300, 2'd2, 8'h80, 8'hFE, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0300, 1'b1}, // R4 self loop
        '{4'd3, 16'h0400, 2'd2, 8'h60, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h0382, 1'b1}, // R3 -128
        '{4'd3, 16'h0400, 2'd2, 8'h60, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0402, 1'b0}, // R3 not taken
        '{4'd3, 16'h0500, 2'd3, 8'hB5, 8'h7F, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h0582, 1'b1}, // R3 +127
        '{4'd3, 16'h0600, 2'd2, 8'hD8, 8'hF0, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h05F2, 1'b1}, // R3
        '{4'd3, 16'h0700, 2'd3, 8'h20, 8'h05, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0703, 1'b0}, // R3
        '{4'd3, 16'h0800, 2'd3, 8'h10, 8'h01, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h0804, 1'b1}, // R3
        '{4'd3, 16'h4000, 2'd3, 8'hD5, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h4003, 1'b1}, // R3 R10
        '{4'd5, 16'h1234, 2'd2, 8'h01, 8'h00, 8'h56, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h1056, 1'b1}, // R5
        '{4'd5, 16'h1234, 2'd2, 8'hF1, 8'h00, 8'hAB, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'h17AB, 1'b1}, // R5
        '{4'd5, 16'h07FE, 2'd2, 8'hE1, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0F00, 1'b1}, // R5 page crossing
        '{4'd7, 16'h0000, 2'd1, 8'h73, 8'h00, 8'h00, 16'h0000, 8'h20, 16'hFFF0, 1'b0, 16'h0010, 1'b1}, // R7 R8
        '{4'd8, 16'hFFFF, 2'd1, 8'h00, 8'h00, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R8
        '{4'd8, 16'hFFFE, 2'd2, 8'h80, 8'h05, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b0, 16'h0005, 1'b1}, // R8
        '{4'd8, 16'h0010, 2'd2, 8'h40, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h0000, 1'b1, 16'hFF92, 1'b1}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] cur_pc = '0;
    logic [1:0]  instr_len = 2'd1;
    logic [7:0]  opcode = '0;
    logic [7:0]  rel_off = '0;
    logic [7:0]  page_lo = '0;
    logic [15:0] abs_addr = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic        cond_taken = 1'b0;
    logic        out_valid;
    logic [15:0] next_pc;
    logic        branch_taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pc_next_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
        .instr_len(instr_len), .opcode(opcode), .rel_off(rel_off),
        .page_lo(page_lo), .abs_addr(abs_addr), .acc(acc), .dptr(dptr),
        .cond_taken(cond_taken), .out_valid(out_valid), .next_pc(next_pc),
        .branch_taken(branch_taken)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1; cur_pc = v.pc; instr_len = v.len; opcode = v.op;
        rel_off = v.rel; page_lo = v.pg; abs_addr = v.abs; acc = v.a;
        dptr = v.dp; cond_taken = v.cond;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid", 16'(out_valid), 16'h0);
        check("R1 pc", next_pc, 16'h0000);
        check("R1 taken", 16'(branch_taken), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-release valid", 16'(out_valid), 16'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("R%0d vec%0d pc", VECS[i].req, i), next_pc, VECS[i].exp_pc);
            // R10 taken flag per kind
            check($sformatf("R10 vec%0d taken", i), 16'(branch_taken), 16'(VECS[i].exp_tk));
            check($sformatf("R9 vec%0d valid", i), 16'(out_valid), 16'h1);
        end

        // R9: idle cycle with scrambled inputs leaves outputs alone
        cur_pc = 16'hAAAA; opcode = 8'h02; abs_addr = 16'h5555; cond_taken = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 idle valid", 16'(out_valid), 16'h0);
        check("R9 hold pc", next_pc, 16'hFF92);
        check("R9 hold taken", 16'(branch_taken), 16'h1);

        // R1: reset mid-run clears the result
        apply(VECS[3]);
        rst_n = 1'b0;
        #1;
        check("R1 async pc", next_pc, 16'h0000);
        check("R1 async taken", 16'(branch_taken), 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule